// File: doc/BRIEF.md
# Page Write Collector with Self-Timed Commit

This block sits between a serial slave engine and a 256 x 8 storage array. While a write transaction is open it gathers incoming data bytes into a one-page buffer of 8 slots. The slot is picked by the low three bits of a shared word address counter. That counter steps only within its page: the three low bits advance after each byte and wrap from 7 to 0, and the five page bits never change. When more than eight bytes arrive, the later ones overwrite earlier slots. A mask records which slots hold data, so a partial page changes only the bytes that were actually sent.

When the stop strobe arrives and at least one byte has been collected, the block opens an internal write window. The window lasts `WRITE_CYCLES` system clocks and busy is high for all of it. In the first eight clocks of the window the block walks the slots in ascending order and issues one array write for each marked slot. The write-protect level suppresses every array write but leaves the busy window in place. While busy is high, all transaction inputs are ignored. A stop that follows no data byte does nothing.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `mem_we` is 0 and `cur_addr` is 0.
- R2: Each accepted byte (`byte_valid` high while `busy` is 0) goes into the slot given by `cur_addr[2:0]`. After it, `cur_addr[2:0]` increases by one and `cur_addr[7:3]` is unchanged. `addr_load` loads `cur_addr` from `addr_in`.
- R3: The in-page offset wraps from 7 to 0 inside the same page. With more than 8 bytes, the last byte received for an offset is the one written to the array.
- R4: A commit writes only the offsets that received a byte, at address `{cur_addr[7:3], offset}`. The number of `mem_we` pulses equals the number of distinct offsets received.
- R5: A stop (`stop_seen` high while `busy` is 0) with at least one collected byte raises `busy` on the next clock. `busy` then stays high for exactly `WRITE_CYCLES` clocks.
- R6: A stop with no collected byte leaves `busy` low and produces no `mem_we`.
- R7: While `wp_level` is 1, `mem_we` stays 0. The busy window after the stop still runs its full length.
- R8: While `busy` is 1, `txn_start`, `addr_load`, `byte_valid` and `stop_seen` have no effect: `cur_addr`, the collected bytes and the array are left as they were.
- R9: `txn_start` discards all bytes collected before it, so only bytes received after the last start are committed.
- R10: After a commit, `cur_addr` equals the last written offset plus one, wrapped within the page, with the page bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start | input | 1 | One-clock strobe: a new transaction begins, so the slot mask is cleared |
| addr_load | input | 1 | One-clock strobe: load the word address counter |
| addr_in | input | ADDR_W | Word address to load |
| byte_valid | input | 1 | One-clock strobe: a data byte was received |
| byte_data | input | DATA_W | Received data byte |
| stop_seen | input | 1 | One-clock strobe: a stop condition was seen |
| wp_level | input | 1 | Write-protect level; 1 blocks array writes |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | High during the self-timed write window |
| cur_addr | output | ADDR_W | Shared word address counter |

## Verification
A table of transactions drives the commit path with several patterns:
- a single byte;
- a partial page that ends exactly at the page edge;
- a partial page that wraps past offset 7;
- a full page;
- an eleven-byte overrun, where last-writer-wins can be told apart from first-writer-wins;
- a protected write;
- a wrap on the top page.

For each transaction the bench compares the whole array image, the write-pulse count, the busy length and the final counter value. Together these separate a wrong slot choice from a wrong page, a missing mask from a stale one, and a window cut short from one held too long. Directed tests then cover three cases: a stop with no data, traffic injected during busy, and a start that abandons bytes already collected.

// File: rtl/pwb_pkg.sv
// Package: shared defaults for the page write collector.
// Assumes: one page holds a power-of-two number of bytes.
package pwb_pkg;
    localparam int unsigned PWB_ADDR_W       = 8;
    localparam int unsigned PWB_DATA_W       = 8;
    localparam int unsigned PWB_PAGE_BYTES   = 8;
    localparam int unsigned PWB_WRITE_CYCLES = 250000;   // 5 ms at 50 MHz
endpackage

// File: rtl/pwb_slot_buffer.sv
// Module: pwb_slot_buffer
// Holds one page of data bytes, one slot per in-page offset, together with
// a mask of the slots written since the last clear.
// Assumes: a clear and a write in the same clock resolve to the clear.
module pwb_slot_buffer #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned PAGE_BYTES = 8,
    localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  wr_en,
    input  logic [OFF_W-1:0]      wr_slot,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [OFF_W-1:0]      rd_slot,
    output logic [DATA_W-1:0]     rd_data,
    output logic [PAGE_BYTES-1:0] mask
);
    logic [DATA_W-1:0] slot_q [PAGE_BYTES];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        // Mark the slot when it is written; drop the mark on clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask[i] <= 1'b0;
            else if (clear)
                mask[i] <= 1'b0;
            else if (wr_en && wr_slot == OFF_W'(i))
                mask[i] <= 1'b1;
        end

        // Capture the data byte destined for this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (!clear && wr_en && wr_slot == OFF_W'(i))
                slot_q[i] <= wr_data;
        end
    end

    // Present the slot chosen by the commit walk.
    always_comb rd_data = slot_q[rd_slot];
endmodule

// File: rtl/pwb_addr_track.sv
// Module: pwb_addr_track
// Shared word address counter. A load takes the full address. A step
// advances only the in-page offset, which wraps so the page bits stay fixed.
// Assumes: load and step are already gated off by the caller while busy.
module pwb_addr_track #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned PAGE_BYTES = 8,
    localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] cur
);
    // Hold, load, or step the offset inside the page.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (load)
            cur <= load_addr;
        else if (step)
            cur[OFF_W-1:0] <= cur[OFF_W-1:0] + OFF_W'(1);
    end

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> cur[ADDR_W-1:OFF_W] == $past(cur[ADDR_W-1:OFF_W])); // R2
endmodule

// File: rtl/pwb_write_timer.sv
// Module: pwb_write_timer
// Self-timed write window. A launch raises busy for exactly WRITE_CYCLES
// clocks. The phase output counts the clocks elapsed inside the window.
// Assumes: WRITE_CYCLES is at least 2; launch is ignored while busy.
module pwb_write_timer #(
    parameter int unsigned WRITE_CYCLES = 250000,
    localparam int unsigned CNT_W       = $clog2(WRITE_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    output logic             busy,
    output logic [CNT_W-1:0] phase,
    output logic             done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

    // The last clock of the window.
    always_comb done = busy && (phase == LAST);

    // Open the window on launch and close it after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            phase <= '0;
        end else if (!busy) begin
            busy  <= launch;
            phase <= '0;
        end else if (done) begin
            busy  <= 1'b0;
            phase <= '0;
        end else begin
            phase <= phase + CNT_W'(1);
        end
    end

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R5
    AST_BUSY_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R5
endmodule

// File: rtl/page_write_ctrl.sv
// Module: page_write_ctrl
// Collects one page of write bytes. On a stop that follows data, it commits
// the marked slots to the array during a self-timed busy window; write
// protect suppresses the array writes.
// Assumes: WRITE_CYCLES >= PAGE_BYTES, so the commit walk fits the window.
// Assumes: the strobes are one clock wide and come from the slave engine.
module page_write_ctrl
    import pwb_pkg::*;
#(
    parameter int unsigned ADDR_W       = PWB_ADDR_W,
    parameter int unsigned DATA_W       = PWB_DATA_W,
    parameter int unsigned PAGE_BYTES   = PWB_PAGE_BYTES,
    parameter int unsigned WRITE_CYCLES = PWB_WRITE_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_seen,
    input  logic              wp_level,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int unsigned OFF_W = $clog2(PAGE_BYTES);
    localparam int unsigned CNT_W = $clog2(WRITE_CYCLES);

    logic                  accept_start, accept_load, accept_byte, launch;
    logic                  win_done, buf_clear;
    logic [CNT_W-1:0]      phase;
    logic [OFF_W-1:0]      walk_slot;
    logic                  walk_active;
    logic [PAGE_BYTES-1:0] mask;
    logic [DATA_W-1:0]     slot_data;

    // Gate the transaction strobes with busy so the window ignores them.
    always_comb begin
        accept_start = txn_start  && !busy;
        accept_load  = addr_load  && !busy;
        accept_byte  = byte_valid && !busy;
        launch       = stop_seen  && !busy && (|mask);
        buf_clear    = accept_start || win_done;
    end

    pwb_slot_buffer #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (buf_clear),
        .wr_en   (accept_byte),
        .wr_slot (cur_addr[OFF_W-1:0]),
        .wr_data (byte_data),
        .rd_slot (walk_slot),
        .rd_data (slot_data),
        .mask    (mask)
    );

    pwb_addr_track #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept_load),
        .load_addr (addr_in),
        .step      (accept_byte),
        .cur       (cur_addr)
    );

    pwb_write_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .busy   (busy),
        .phase  (phase),
        .done   (win_done)
    );

    // Walk the slots in ascending order during the first phases of the window.
    always_comb begin
        walk_active = busy && (phase < CNT_W'(PAGE_BYTES));
        walk_slot   = phase[OFF_W-1:0];
    end

    // Issue one array write per marked slot unless write protect is high.
    always_comb begin
        mem_we    = walk_active && mask[walk_slot] && !wp_level;
        mem_addr  = {cur_addr[ADDR_W-1:OFF_W], walk_slot};
        mem_wdata = slot_data;
    end

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && !busy && mask != '0) |=> busy); // R5
    AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && !busy && mask == '0) |=> !busy); // R6
    AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R4
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_addr)); // R8
    AST_WE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $countones(mask) != 0); // R4
endmodule

// File: tb/page_write_ctrl_bench.sv
module page_write_ctrl_bench;
    localparam int WC = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 0, addr_load = 0, byte_valid = 0, stop_seen = 0, wp_level = 0;
    logic [7:0] addr_in = 0, byte_data = 0;
    logic       mem_we, busy;
    logic [7:0] mem_addr, mem_wdata, cur_addr;

    int checks = 0, failures = 0, wr_count = 0;
    logic [7:0] obs_mem [256];
    logic [7:0] exp_mem [256];

    // {start[24:17], count[16:9], base[8:1], wp[0]}
    localparam int NV = 7;
    localparam logic [24:0] VEC [NV] = '{
        {8'h10, 8'd1,  8'hA5, 1'b0},
        {8'h2D, 8'd3,  8'h30, 1'b0},
        {8'h46, 8'd5,  8'h50, 1'b0},
        {8'h60, 8'd8,  8'h70, 1'b0},
        {8'h83, 8'd11, 8'h90, 1'b0},
        {8'hA0, 8'd4,  8'hC0, 1'b1},
        {8'hF7, 8'd2,  8'hE0, 1'b0}
    };

    page_write_ctrl #(.WRITE_CYCLES(WC)) u_page_write_ctrl (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .addr_load(addr_load),
        .addr_in(addr_in), .byte_valid(byte_valid), .byte_data(byte_data),
        .stop_seen(stop_seen), .wp_level(wp_level), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .cur_addr(cur_addr)
    );

    always #10 clk = ~clk;

    initial for (int i = 0; i < 256; i++) begin obs_mem[i] = 8'h00; exp_mem[i] = 8'h00; end

    always @(posedge clk) if (mem_we) begin
        obs_mem[mem_addr] <= mem_wdata;
        wr_count <= wr_count + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic mem_cmp(input string tag);
        int bad = 0;
        for (int i = 0; i < 256; i++) if (obs_mem[i] !== exp_mem[i]) bad++;
        chk(tag, bad, 0);
    endtask

    task automatic pulse_start(); txn_start = 1; @(negedge clk); txn_start = 0; endtask
    task automatic pulse_load(input logic [7:0] a); addr_load = 1; addr_in = a; @(negedge clk); addr_load = 0; endtask
    task automatic pulse_byte(input logic [7:0] d); byte_valid = 1; byte_data = d; @(negedge clk); byte_valid = 0; endtask

    // Stop, then count the busy clocks that follow.
    task automatic stop_and_measure(output int blen);
        stop_seen = 1; @(negedge clk); stop_seen = 0;
        blen = 0;
        while (busy) begin blen++; @(negedge clk); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int blen, w0;
        logic [7:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 cur_addr", cur_addr, 0);

        // R6: stop with nothing collected.
        w0 = wr_count;
        pulse_start(); pulse_load(8'h55);
        stop_and_measure(blen);
        chk("R6 busy length", blen, 0);
        chk("R6 writes", wr_count - w0, 0);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] st, n, base; logic wp; int distinct;
            st = VEC[v][24:17]; n = VEC[v][16:9]; base = VEC[v][8:1]; wp = VEC[v][0];
            w0 = wr_count;
            pulse_start(); pulse_load(st);
            a = st;
            for (int k = 0; k < n; k++) begin
                pulse_byte(base + 8'(k));
                if (!wp) exp_mem[a] = base + 8'(k);
                a = {a[7:3], a[2:0] + 3'd1};
            end
            chk($sformatf("R2 counter after bytes v%0d", v), cur_addr, a);
            wp_level = wp;
            stop_and_measure(blen);
            wp_level = 0;
            distinct = (n > 8) ? 8 : n;
            chk($sformatf("R5 busy length v%0d", v), blen, WC);
            chk($sformatf("R4 R7 write count v%0d", v), wr_count - w0, wp ? 0 : distinct);
            mem_cmp($sformatf("R3 R4 R7 array image v%0d", v));
            chk($sformatf("R10 counter after commit v%0d", v), cur_addr, a);
        end

        // R8: traffic during busy is ignored.
        pulse_start(); pulse_load(8'h31); pulse_byte(8'h5A);
        exp_mem[8'h31] = 8'h5A;
        stop_seen = 1; @(negedge clk); stop_seen = 0;
        pulse_start(); pulse_load(8'h00); pulse_byte(8'hEE);
        stop_seen = 1; @(negedge clk); stop_seen = 0;
        while (busy) @(negedge clk);
        chk("R8 counter unchanged", cur_addr, 8'h32);
        w0 = wr_count;
        stop_and_measure(blen);
        chk("R8 byte in window dropped", blen, 0);
        chk("R8 no extra write", wr_count - w0, 0);
        mem_cmp("R8 array image");

        // R9: start discards bytes collected before it.
        w0 = wr_count;
        pulse_start(); pulse_load(8'hC2);
        pulse_byte(8'h11); pulse_byte(8'h22); pulse_byte(8'h33);
        pulse_start(); pulse_load(8'hC5); pulse_byte(8'h44);
        exp_mem[8'hC5] = 8'h44;
        stop_and_measure(blen);
        chk("R9 write count", wr_count - w0, 1);
        mem_cmp("R9 array image");
        chk("R9 counter", cur_addr, 8'hC6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule